// File: doc/BRIEF.md
# Execution Unit Occupancy Scoreboard

This block keeps track of which functional units of an out-of-order core are occupied, and when their results come back. The units are grouped into classes with different amounts of pipelining. An issue request carries five fields: a unit class, an optional restriction to the even-indexed or odd-indexed units of that class, a result latency, a busy time and a tag. The scoreboard accepts at most one request per cycle, and only when a unit that satisfies the request is idle. It then reserves that unit for the busy time. When the latency has elapsed, it emits the tag on a writeback stream.

Busy time and result latency are independent of each other. A fully pipelined adder has a busy time of one and takes new work every cycle, but still returns its result two or three cycles later. A decimal or quad-precision operation can hold its single unit for more than sixty cycles. The issue logic uses the per-class idle counts to steer requests. The writeback tags wake dependent operations elsewhere. Operand dependencies are not tracked here.

Top module: `exec_occupancy_sb`

## Requirements
- R1: While reset is held and immediately after it, every unit is idle, `free_cnt` shows the full population of every class, and `wb_valid` is low.
- R2: The class codes and unit counts are: 0 integer ALU with 4 units, 1 integer divide with 2, 2 floating-point with 4, 3 decimal/quad with 1, 4 load/store with 4, 5 branch with 1, and 6 crypto with 1. `free_cnt` packs class c into bits [3c+2:3c].
- R3: `req_ready` is high exactly when the named class has an idle unit that matches `req_sub` and the writeback structure has room. `grant_valid` equals `req_valid && req_ready`. A request that is not granted changes no state.
- R4: `req_sub` codes are 0 for any unit, 1 for even index only and 2 for odd index only. Code 3 is never granted. The index counts units within the class, starting at 0.
- R5: Among the matching idle units, the lowest index is granted, and that index appears on `grant_idx` in the same cycle.
- R6: A unit granted in cycle c with busy time b ≥ 1 cannot be granted in cycles c+1 … c+b−1 and is idle again in cycle c+b. A busy time of 0 behaves like 1.
- R7: `free_cnt` for each class equals the number of idle units of that class in the current cycle.
- R8: A request granted in cycle c with latency L ≥ 1 produces a one-cycle `wb_valid` pulse carrying `req_tag` in cycle c+L, unless R9 applies. A latency of 0 behaves like 1.
- R9: If a result's cycle is already taken by an earlier grant, the later result moves to the first following cycle that is still free, so older grants are reported first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Issue request present |
| req_ready | output | 1 | A matching unit and a writeback slot are available |
| req_cls | input | 3 | Unit class code (R2) |
| req_sub | input | 2 | Subset restriction code (R4) |
| req_lat | input | 7 | Result latency in cycles |
| req_busy | input | 6 | Cycles the unit stays occupied |
| req_tag | input | 5 | Tag returned on writeback |
| grant_valid | output | 1 | Request accepted this cycle |
| grant_idx | output | 2 | Index within the class of the granted unit |
| free_cnt | output | 21 | Idle unit count per class, 3 bits per class |
| wb_valid | output | 1 | Result completes this cycle |
| wb_tag | output | 5 | Tag of the completing result |

## Verification
The bench uses the default widths. A 7-bit latency gives a 128-slot writeback structure, and a 6-bit busy time covers the 62-cycle decimal occupancy. This allows directed runs at the real extremes: a 76-cycle result with 62 busy cycles, and divide reservations of 8 cycles. Short random latencies then produce frequent writeback collisions and chains of displaced results. Mixed busy times with even/odd restrictions keep individual units of the ALU and floating-point classes blocked while their siblings stay available.

// File: rtl/exec_sb_pkg.sv
package exec_sb_pkg;
  localparam int NCLS  = 7;
  localparam int CLS_W = 3;
  localparam int CLS_UNITS [NCLS] = '{4, 2, 4, 1, 4, 1, 1};

  function automatic int total_units();
    int s;
    s = 0;
    for (int c = 0; c < NCLS; c++) s += CLS_UNITS[c];
    return s;
  endfunction

  function automatic int max_units();
    int m;
    m = 1;
    for (int c = 0; c < NCLS; c++) if (CLS_UNITS[c] > m) m = CLS_UNITS[c];
    return m;
  endfunction

  // class of flat unit u
  function automatic int unit_cls(int u);
    int base;
    base = 0;
    for (int c = 0; c < NCLS; c++) begin
      if (u < base + CLS_UNITS[c]) return c;
      base += CLS_UNITS[c];
    end
    return 0;
  endfunction

  // index of flat unit u within its class
  function automatic int unit_idx(int u);
    int base;
    base = 0;
    for (int c = 0; c < NCLS; c++) begin
      if (u < base + CLS_UNITS[c]) return u - base;
      base += CLS_UNITS[c];
    end
    return 0;
  endfunction

  localparam int NUNITS = total_units();
  localparam int MAXU   = max_units();
  localparam int CNT_W  = $clog2(MAXU + 1);
  localparam int IDX_W  = (MAXU > 1) ? $clog2(MAXU) : 1;
  localparam int UID_W  = (NUNITS > 1) ? $clog2(NUNITS) : 1;

  typedef enum logic [1:0] {
    SUB_ANY  = 2'd0,
    SUB_EVEN = 2'd1,
    SUB_ODD  = 2'd2
  } sub_e;
endpackage

// File: rtl/exec_sb_units.sv
module exec_sb_units
  import exec_sb_pkg::*;
#(
  parameter int BUSY_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CLS_W-1:0]        req_cls,
  input  logic [1:0]              req_sub,
  input  logic [BUSY_W-1:0]       req_busy,
  input  logic                    take,
  output logic                    found,
  output logic [IDX_W-1:0]        sel_idx,
  output logic [NCLS*CNT_W-1:0]   free_cnt
);
  logic [BUSY_W-1:0] cnt_q [NUNITS];
  logic [BUSY_W-1:0] cnt_d [NUNITS];
  logic [NUNITS-1:0] idle;
  logic [NUNITS-1:0] elig;
  logic [NUNITS-1:0] upd;
  logic [UID_W-1:0]  sel_u;

  for (genvar u = 0; u < NUNITS; u++) begin : g_unit
    localparam int UC = unit_cls(u);
    localparam int UI = unit_idx(u);
    localparam bit ODD = (UI % 2) == 1;

    assign idle[u] = (cnt_q[u] == '0);
    assign elig[u] = idle[u] && (req_cls == CLS_W'(UC)) &&
                     ((req_sub == SUB_ANY) ||
                      (req_sub == SUB_EVEN && !ODD) ||
                      (req_sub == SUB_ODD  &&  ODD));

    always_comb begin
      cnt_d[u] = cnt_q[u];
      upd[u]   = 1'b0;
      if (!idle[u]) begin
        cnt_d[u] = cnt_q[u] - 1'b1;
        upd[u]   = 1'b1;
      end
      if (take && (sel_u == UID_W'(u))) begin
        cnt_d[u] = (req_busy == '0) ? '0 : req_busy - 1'b1;
        upd[u]   = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q[u] <= '0;
      else if (upd[u]) cnt_q[u] <= cnt_d[u];
    end
  end

  // lowest eligible unit wins
  always_comb begin
    found   = 1'b0;
    sel_u   = '0;
    sel_idx = '0;
    for (int u = NUNITS - 1; u >= 0; u--) begin
      if (elig[u]) begin
        found   = 1'b1;
        sel_u   = UID_W'(u);
        sel_idx = IDX_W'(unit_idx(u));
      end
    end
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic [CNT_W-1:0] fc;
    always_comb begin
      fc = '0;
      for (int u = 0; u < NUNITS; u++)
        if (unit_cls(u) == c && idle[u]) fc = fc + 1'b1;
    end
    assign free_cnt[c*CNT_W +: CNT_W] = fc;
  end
endmodule

// File: rtl/exec_sb_wbq.sv
module exec_sb_wbq #(
  parameter int LAT_W = 7,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LAT_W-1:0] push_lat,
  input  logic [TAG_W-1:0] push_tag,
  output logic             room,
  output logic             wb_valid,
  output logic [TAG_W-1:0] wb_tag
);
  localparam int DEPTH = 2 ** LAT_W;

  logic [DEPTH-1:0] vld_q, vld_d, sh_v;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [TAG_W-1:0] tag_d [DEPTH];
  logic [TAG_W-1:0] sh_t  [DEPTH];
  logic [LAT_W-1:0] start;
  logic [LAT_W-1:0] pos;

  assign start = (push_lat == '0) ? '0 : push_lat - 1'b1;

  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      sh_v[k] = (k < DEPTH - 1) ? vld_q[(k + 1) % DEPTH] : 1'b0;
      sh_t[k] = tag_q[(k + 1) % DEPTH];
    end
  end

  // first free slot at or above the requested one
  always_comb begin
    room = 1'b0;
    pos  = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if ((LAT_W'(k) >= start) && !sh_v[k]) begin
        room = 1'b1;
        pos  = LAT_W'(k);
      end
    end
  end

  always_comb begin
    vld_d = sh_v;
    for (int k = 0; k < DEPTH; k++) tag_d[k] = sh_t[k];
    if (push && room) begin
      vld_d[pos] = 1'b1;
      tag_d[pos] = push_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tag_q[k] <= '0;
      else if (vld_d[k]) tag_q[k] <= tag_d[k];
    end
  end

  assign wb_valid = vld_q[0];
  assign wb_tag   = tag_q[0];
endmodule

// File: rtl/exec_occupancy_sb.sv
module exec_occupancy_sb
  import exec_sb_pkg::*;
#(
  parameter int LAT_W  = 7,
  parameter int BUSY_W = 6,
  parameter int TAG_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [CLS_W-1:0]      req_cls,
  input  logic [1:0]            req_sub,
  input  logic [LAT_W-1:0]      req_lat,
  input  logic [BUSY_W-1:0]     req_busy,
  input  logic [TAG_W-1:0]      req_tag,
  output logic                  grant_valid,
  output logic [IDX_W-1:0]      grant_idx,
  output logic [NCLS*CNT_W-1:0] free_cnt,
  output logic                  wb_valid,
  output logic [TAG_W-1:0]      wb_tag
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       unit_found;
  logic       wb_room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign req_ready   = unit_found && wb_room;
  assign grant_valid = req_valid && req_ready;

  exec_sb_units #(.BUSY_W(BUSY_W)) u_units (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .req_cls  (req_cls),
    .req_sub  (req_sub),
    .req_busy (req_busy),
    .take     (grant_valid),
    .found    (unit_found),
    .sel_idx  (grant_idx),
    .free_cnt (free_cnt)
  );

  exec_sb_wbq #(.LAT_W(LAT_W), .TAG_W(TAG_W)) u_wbq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .push     (grant_valid),
    .push_lat (req_lat),
    .push_tag (req_tag),
    .room     (wb_room),
    .wb_valid (wb_valid),
    .wb_tag   (wb_tag)
  );
endmodule

// File: rtl/exec_sb_chk.sv
module exec_sb_chk
  import exec_sb_pkg::*;
#(
  parameter int BUSY_W = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [CLS_W-1:0]      req_cls,
  input logic [BUSY_W-1:0]     req_busy,
  input logic                  grant_valid,
  input logic [NCLS*CNT_W-1:0] free_cnt
);
  for (genvar c = 0; c < NCLS; c++) begin : g_c
    // R3: no idle unit in the class means no acceptance
    p_ready_needs_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_cls == CLS_W'(c) && free_cnt[c*CNT_W +: CNT_W] == '0) |-> !req_ready);

    // R7: the count never exceeds the class population
    p_free_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      free_cnt[c*CNT_W +: CNT_W] <= CNT_W'(CLS_UNITS[c]));

    // R6: without a grant, units can only become idle
    p_free_rise_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_valid |=> free_cnt[c*CNT_W +: CNT_W] >= $past(free_cnt[c*CNT_W +: CNT_W]));

    if (CLS_UNITS[c] == 1) begin : g_single
      // R6: a multi-cycle reservation empties a single-unit class next cycle
      p_single_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && req_cls == CLS_W'(c) && req_busy >= 2) |=>
          free_cnt[c*CNT_W +: CNT_W] == '0);
    end
  end
endmodule

bind exec_occupancy_sb exec_sb_chk #(.BUSY_W(BUSY_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_cls     (req_cls),
  .req_busy    (req_busy),
  .grant_valid (grant_valid),
  .free_cnt    (free_cnt)
);

// File: tb/exec_occupancy_sb_bench.sv
`timescale 1ns/1ps
module exec_occupancy_sb_bench;
  localparam int NC = 7;
  localparam int NU = 17;
  localparam int CW = 3;
  localparam int DEPTH = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_cls = '0;
  logic [1:0]  req_sub = '0;
  logic [6:0]  req_lat = '0;
  logic [5:0]  req_busy = '0;
  logic [4:0]  req_tag = '0;
  logic        grant_valid;
  logic [1:0]  grant_idx;
  logic [20:0] free_cnt;
  logic        wb_valid;
  logic [4:0]  wb_tag;

  always #2 clk = ~clk;

  exec_occupancy_sb u_exec_occupancy_sb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cls(req_cls), .req_sub(req_sub), .req_lat(req_lat), .req_busy(req_busy),
    .req_tag(req_tag), .grant_valid(grant_valid), .grant_idx(grant_idx),
    .free_cnt(free_cnt), .wb_valid(wb_valid), .wb_tag(wb_tag)
  );

  int checks = 0;
  int errors = 0;
  string ctx = "R1";
  int cls_n [NC] = '{4, 2, 4, 1, 4, 1, 1};
  int ucls [NU];
  int uidx [NU];
  int ubusy [NU];
  int wb_at [int];
  int cyc = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", ctx, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input int cls, input int sub, input int lat,
                      input int busy, input int tag);
    int sel, slot, eff;
    bit rdy, room;
    @(negedge clk);
    req_valid = v; req_cls = 3'(cls); req_sub = 2'(sub);
    req_lat = 7'(lat); req_busy = 6'(busy); req_tag = 5'(tag);
    #1;
    // model: per-class idle counts
    for (int c = 0; c < NC; c++) begin
      int n;
      n = 0;
      for (int u = 0; u < NU; u++) if (ucls[u] == c && ubusy[u] == 0) n++;
      chk(free_cnt[c*CW +: CW] == CW'(n), "free_cnt", int'(free_cnt[c*CW +: CW]), n);
    end
    sel = -1;
    for (int u = NU - 1; u >= 0; u--)
      if (ucls[u] == cls && ubusy[u] == 0 &&
          (sub == 0 || (sub == 1 && uidx[u] % 2 == 0) || (sub == 2 && uidx[u] % 2 == 1)))
        sel = u;
    eff = (lat == 0) ? 1 : lat;
    slot = cyc + eff;
    while (wb_at.exists(slot)) slot++;
    room = (slot - cyc - 1) < DEPTH;
    rdy = (sel >= 0) && room;
    chk(req_ready == rdy, "req_ready", int'(req_ready), int'(rdy));
    chk(grant_valid == (v && rdy), "grant_valid", int'(grant_valid), int'(v && rdy));
    if (v && rdy)
      chk(grant_idx == 2'(uidx[sel]), "grant_idx", int'(grant_idx), uidx[sel]);
    chk(wb_valid == wb_at.exists(cyc), "wb_valid", int'(wb_valid), int'(wb_at.exists(cyc)));
    if (wb_at.exists(cyc))
      chk(wb_tag == 5'(wb_at[cyc]), "wb_tag", int'(wb_tag), wb_at[cyc]);
    // model: advance one clock
    for (int u = 0; u < NU; u++) if (ubusy[u] > 0) ubusy[u]--;
    if (v && rdy) begin
      ubusy[sel] = (busy == 0) ? 0 : busy - 1;
      wb_at[slot] = tag;
    end
    if (wb_at.exists(cyc)) wb_at.delete(cyc);
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1, 1, 0);
  endtask

  initial begin
    int k;
    k = 0;
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < cls_n[c]; i++) begin
        ucls[k] = c; uidx[k] = i; ubusy[k] = 0; k++;
      end

    // R1: reset state, then synchronous release
    repeat (3) @(posedge clk);
    #1;
    chk(wb_valid == 1'b0, "wb_valid in reset", int'(wb_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(3);

    // R2: every class reports its full population
    ctx = "R2";
    for (int c = 0; c < NC; c++)
      chk(free_cnt[c*CW +: CW] == CW'(cls_n[c]), "class population",
          int'(free_cnt[c*CW +: CW]), cls_n[c]);

    // R5 R6: pipelined ALU keeps unit 0 while busy 1; busy 3 walks across units
    ctx = "R5";
    for (int i = 0; i < 4; i++) step(1, 0, 0, 2, 1, i);
    for (int i = 0; i < 5; i++) step(1, 0, 0, 3, 3, 8 + i);
    idle(6);

    // R4: even / odd subsets on floating-point units
    ctx = "R4";
    step(1, 2, 1, 7, 8, 1);
    step(1, 2, 1, 7, 8, 2);
    step(1, 2, 1, 7, 8, 3);
    step(1, 2, 2, 5, 4, 4);
    step(1, 2, 2, 5, 4, 5);
    step(1, 2, 3, 5, 1, 6);
    step(1, 2, 0, 5, 1, 7);
    idle(12);

    // R6: divide busy 8 and the decimal unit at 76/62
    ctx = "R6";
    step(1, 1, 0, 16, 8, 10);
    step(1, 1, 0, 24, 8, 11);
    step(1, 1, 0, 40, 8, 12);
    for (int i = 0; i < 8; i++) step(1, 1, 0, 5, 1, 13);
    step(1, 3, 0, 76, 62, 20);
    for (int i = 0; i < 64; i++) step(1, 3, 0, 12, 1, 21);
    idle(80);

    // R8: latency edge values, including zero
    ctx = "R8";
    step(1, 4, 0, 0, 1, 3);
    idle(2);
    step(1, 4, 0, 1, 1, 4);
    idle(2);
    step(1, 5, 0, 2, 1, 5);
    step(1, 6, 0, 6, 1, 6);
    idle(8);

    // R9: collisions push the younger result later
    ctx = "R9";
    step(1, 0, 0, 3, 1, 17);
    step(1, 0, 0, 2, 1, 18);
    step(1, 0, 0, 1, 1, 19);
    step(1, 4, 0, 4, 1, 22);
    step(1, 4, 0, 3, 1, 23);
    idle(8);

    // R3 R7: random mix
    ctx = "R3";
    for (int i = 0; i < 4000; i++) begin
      int cl;
      cl = $urandom_range(0, 6);
      if (cl == 3 && $urandom_range(0, 3) == 0)
        step($urandom_range(0, 1), cl, $urandom_range(0, 3), $urandom_range(12, 76),
             $urandom_range(11, 62), $urandom_range(0, 31));
      else
        step($urandom_range(0, 1), cl, $urandom_range(0, 3), $urandom_range(0, 40),
             $urandom_range(0, 12), $urandom_range(0, 31));
    end
    ctx = "R7";
    idle(90);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule